// File: doc/BRIEF.md
# Multi-Stage Probabilistic Heavy-Hitter Table

This block estimates the sizes of the largest flows in a packet stream. It keeps a set of small tables, one for each pipeline stage. Each table entry holds a flow identifier and a counter. A packet brings a flow identifier. In each stage it touches exactly one entry, at an index that the stage computes from the identifier. If a touched entry already holds the packet's flow, that counter goes up by one. If no touched entry holds the flow, the block finds the smallest counter among the touched entries and the stage that holds it. It then draws a random bit pattern and decides whether that entry should be taken over. The chance of a takeover shrinks as the counter grows.

The block always forwards the packet unchanged. A takeover is never done in line. Instead the block emits a request that carries the flow, the chosen stage and the smallest count. The surrounding pipeline sends that request back on the recirculation input. On that second pass the entry is overwritten. A recirculated request wins over a new packet in the same cycle, and the blocked packet sees a stall. A readout command streams every entry while all updates are held off.

Top module: `hh_table_top`

## Requirements
- R1: After reset every entry is empty (used flag 0) and holds the count INIT_COUNT (default 100). No forward, request or readout output is valid.
- R2: Stage s (counted from 0) uses the index `flow[IDX_W-1:0] ^ flow[IDX_W*(s+1) +: IDX_W]`. This applies both to packet lookups and to recirculated writes.
- R3: If a used entry at the packet's index in some stage holds the packet's flow, only the lowest such stage counts up by 1. The count saturates at 2^CNT_W-1, and no takeover request is issued for that packet.
- R4: Every accepted packet appears on fwdValid/fwdFlow one clock later with its flow unchanged. A takeover request is only ever valid together with a forwarded packet.
- R5: For an unmatched packet, any request carries the packet's flow, the smallest count among the touched entries and the stage that holds it. Empty entries take part with their stored count, and on a tie the lowest stage wins.
- R6: For a minimum count c, let N be the largest integer with 2^N <= c+1. The request is issued when the low N bits of the random word are all zero, so the rate is 2^-N: 1/64 for c=100 and 1/2 for c=1.
- R7: An accepted recirculation write sets the entry at (recStage, index of recFlow) to used, with flow recFlow and count recCount+1 (saturating at 2^CNT_W-1).
- R8: When recValid and pktValid are both high and no readout is running, the recirculation write is taken. The packet is not taken: pktStall is high and no forward follows.
- R9: A dumpStart pulse while idle streams STAGES*DEPTH records, one per cycle, starting the cycle after next. Records run stage by stage and by ascending index within a stage. While dumpBusy is high, pktStall and recStall follow pktValid and recValid and the tables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | New packet present |
| pktFlow | input | ID_W | Flow identifier of new packet |
| pktStall | output | 1 | New packet not taken this cycle |
| recValid | input | 1 | Recirculated takeover present |
| recFlow | input | ID_W | Flow to install |
| recStage | input | STAGE_W | Stage to overwrite |
| recCount | input | CNT_W | Minimum count carried by the request |
| recStall | output | 1 | Recirculated takeover not taken this cycle |
| fwdValid | output | 1 | Forwarded packet valid |
| fwdFlow | output | ID_W | Forwarded flow identifier |
| reqValid | output | 1 | Takeover request valid |
| reqFlow | output | ID_W | Flow of the request |
| reqStage | output | STAGE_W | Stage holding the minimum |
| reqMin | output | CNT_W | Minimum count seen |
| dumpStart | input | 1 | Start a readout |
| dumpBusy | output | 1 | Readout in progress |
| dumpValid | output | 1 | Readout record valid |
| dumpStage | output | STAGE_W | Stage of record |
| dumpIndex | output | IDX_W | Index of record |
| dumpUsed | output | 1 | Entry holds a flow |
| dumpFlow | output | ID_W | Stored flow |
| dumpCount | output | CNT_W | Stored count |

## Verification
The embedded properties watch every cycle for the following. Each accepted packet is forwarded one cycle later with the same flow. A recirculation wins over a packet. Requests come only with a forward, carry a legal stage and a non-zero count, and never come for a matched packet. A readout ends exactly after its last entry. The bench's scenarios cover the rest. A near-exhaustive sweep of recirculated writes checks the hash index of each stage through readout. Repeated hits check the increment and saturation. Staged table contents check the minimum and tie-breaking choice. Long runs of unmatched packets check that the request rate fits the coin rule.

// File: rtl/hhPkg.sv
package hhPkg;
  typedef struct packed {
    logic lookup;    // a new packet is taken this cycle
    logic recWrite;  // a recirculated takeover is taken this cycle
    logic dumpRead;  // one readout record is read this cycle
  } hhStrobes_t;
endpackage

// File: rtl/hhCoin.sv
module hhCoin #(
  parameter int CNT_W = 16,
  parameter int RND_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cmin,
  output logic             heads
);
  logic [RND_W-1:0] rnd;
  logic             feedback;
  logic [CNT_W:0]   biased;
  logic [CNT_W-1:0] mask;
  int               topBit;

  assign feedback = rnd[RND_W-1] ^ rnd[RND_W-2] ^ rnd[RND_W-3] ^ rnd[RND_W-8];

  always_ff @(posedge clk) begin
    if (!rstN) rnd <= RND_W'(24'h5A3C91);
    else       rnd <= {rnd[RND_W-2:0], feedback};
  end

  // N = floor(log2(cmin+1)); heads when the low N random bits are zero
  always_comb begin
    biased = {1'b0, cmin} + {{CNT_W{1'b0}}, 1'b1};
    topBit = 0;
    for (int i = 0; i <= CNT_W; i++) begin
      if (biased[i]) topBit = i;
    end
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (i < topBit);
    end
    heads = ((rnd[CNT_W-1:0] & mask) == '0);
  end
endmodule

// File: rtl/hhCtrl.sv
module hhCtrl
  import hhPkg::*;
#(
  parameter int STAGES  = 3,
  parameter int IDX_W   = 3,
  parameter int STAGE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pktValid,
  input  logic               recValid,
  input  logic               dumpStart,
  output hhStrobes_t         strb,
  output logic               pktStall,
  output logic               recStall,
  output logic               dumpBusy,
  output logic [STAGE_W-1:0] curStage,
  output logic [IDX_W-1:0]   curIndex
);
  logic busy;
  logic lastRec;

  assign lastRec  = (curStage == STAGE_W'(STAGES-1)) && (curIndex == '1);
  assign dumpBusy = busy;

  always_comb begin
    strb.recWrite = recValid && !busy;
    strb.lookup   = pktValid && !busy && !recValid;
    strb.dumpRead = busy;
    pktStall      = pktValid && (busy || recValid);
    recStall      = recValid && busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      curStage <= '0;
      curIndex <= '0;
    end else if (!busy) begin
      if (dumpStart) begin
        busy     <= 1'b1;
        curStage <= '0;
        curIndex <= '0;
      end
    end else if (lastRec) begin
      busy <= 1'b0;
    end else if (curIndex == '1) begin
      curIndex <= '0;
      curStage <= curStage + 1'b1;
    end else begin
      curIndex <= curIndex + 1'b1;
    end
  end

  // R9: the readout ends right after the last stage's last index
  p_dump_length_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(curStage) == STAGE_W'(STAGES-1)) && ($past(curIndex) == '1));
endmodule

// File: rtl/hhDatapath.sv
module hhDatapath
  import hhPkg::*;
#(
  parameter int STAGES     = 3,
  parameter int IDX_W      = 3,
  parameter int ID_W       = 16,
  parameter int CNT_W      = 16,
  parameter int INIT_COUNT = 100,
  parameter int STAGE_W    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  hhStrobes_t         strb,
  input  logic [ID_W-1:0]    pktFlow,
  input  logic [ID_W-1:0]    recFlow,
  input  logic [STAGE_W-1:0] recStage,
  input  logic [CNT_W-1:0]   recCount,
  input  logic [STAGE_W-1:0] curStage,
  input  logic [IDX_W-1:0]   curIndex,
  input  logic               heads,
  output logic [CNT_W-1:0]   minCount,
  output logic               fwdValid,
  output logic [ID_W-1:0]    fwdFlow,
  output logic               reqValid,
  output logic [ID_W-1:0]    reqFlow,
  output logic [STAGE_W-1:0] reqStage,
  output logic [CNT_W-1:0]   reqMin,
  output logic               dumpValid,
  output logic [STAGE_W-1:0] dumpStage,
  output logic [IDX_W-1:0]   dumpIndex,
  output logic               dumpUsed,
  output logic [ID_W-1:0]    dumpFlow,
  output logic [CNT_W-1:0]   dumpCount
);
  localparam int DEPTH = 1 << IDX_W;

  logic [STAGES-1:0] hit;
  logic [STAGES-1:0] firstHit;
  logic              anyHit;
  logic [CNT_W-1:0]  visCnt  [STAGES];
  logic              rdUsed  [STAGES];
  logic [ID_W-1:0]   rdFlow  [STAGES];
  logic [CNT_W-1:0]  rdCount [STAGES];
  logic [STAGE_W-1:0] minStage;
  logic [CNT_W-1:0]  recNext;
  logic              selUsed;
  logic [ID_W-1:0]   selFlow;
  logic [CNT_W-1:0]  selCount;

  assign recNext = (recCount == '1) ? recCount : recCount + 1'b1;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic             used [DEPTH];
    logic [ID_W-1:0]  ids  [DEPTH];
    logic [CNT_W-1:0] cnts [DEPTH];
    logic [IDX_W-1:0] pktIdx;
    logic [IDX_W-1:0] recIdx;
    logic             recHere;

    assign pktIdx  = pktFlow[IDX_W-1:0] ^ pktFlow[IDX_W*(s+1) +: IDX_W];
    assign recIdx  = recFlow[IDX_W-1:0] ^ recFlow[IDX_W*(s+1) +: IDX_W];
    assign recHere = (int'(recStage) == s);

    assign hit[s]     = used[pktIdx] && (ids[pktIdx] == pktFlow);
    assign visCnt[s]  = cnts[pktIdx];
    assign rdUsed[s]  = used[curIndex];
    assign rdFlow[s]  = ids[curIndex];
    assign rdCount[s] = cnts[curIndex];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) begin
          used[i] <= 1'b0;
          ids[i]  <= '0;
          cnts[i] <= CNT_W'(INIT_COUNT);
        end
      end else if (strb.lookup && firstHit[s]) begin
        if (cnts[pktIdx] != '1) cnts[pktIdx] <= cnts[pktIdx] + 1'b1;
      end else if (strb.recWrite && recHere) begin
        used[recIdx] <= 1'b1;
        ids[recIdx]  <= recFlow;
        cnts[recIdx] <= recNext;
      end
    end
  end

  assign anyHit   = |hit;
  assign firstHit = hit & (~hit + 1'b1);

  // approximate minimum: strict compare keeps the lowest stage on ties
  always_comb begin
    minCount = visCnt[0];
    minStage = '0;
    for (int s = 1; s < STAGES; s++) begin
      if (visCnt[s] < minCount) begin
        minCount = visCnt[s];
        minStage = STAGE_W'(s);
      end
    end
  end

  always_comb begin
    selUsed  = 1'b0;
    selFlow  = '0;
    selCount = '0;
    for (int s = 0; s < STAGES; s++) begin
      if (int'(curStage) == s) begin
        selUsed  = rdUsed[s];
        selFlow  = rdFlow[s];
        selCount = rdCount[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid  <= 1'b0;
      fwdFlow   <= '0;
      reqValid  <= 1'b0;
      reqFlow   <= '0;
      reqStage  <= '0;
      reqMin    <= '0;
      dumpValid <= 1'b0;
      dumpStage <= '0;
      dumpIndex <= '0;
      dumpUsed  <= 1'b0;
      dumpFlow  <= '0;
      dumpCount <= '0;
    end else begin
      fwdValid  <= strb.lookup;
      reqValid  <= strb.lookup && !anyHit && heads;
      dumpValid <= strb.dumpRead;
      if (strb.lookup) begin
        fwdFlow  <= pktFlow;
        reqFlow  <= pktFlow;
        reqStage <= minStage;
        reqMin   <= minCount;
      end
      if (strb.dumpRead) begin
        dumpStage <= curStage;
        dumpIndex <= curIndex;
        dumpUsed  <= selUsed;
        dumpFlow  <= selFlow;
        dumpCount <= selCount;
      end
    end
  end

  // R4: a request only accompanies a forwarded packet
  p_req_with_fwd_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> fwdValid);
  // R5: the request names an existing stage
  p_req_stage_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (int'(reqStage) < STAGES));
  // R5: stored counts never drop to zero, so a reported minimum is non-zero
  p_req_min_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqMin != '0));
  // R3: a matched lookup never yields a request
  p_no_req_on_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lookup && anyHit) |=> !reqValid);
endmodule

// File: rtl/hh_table_top.sv
module hh_table_top
  import hhPkg::*;
#(
  parameter int STAGES     = 3,
  parameter int IDX_W      = 3,
  parameter int ID_W       = 16,
  parameter int CNT_W      = 16,
  parameter int INIT_COUNT = 100,
  parameter int RND_W      = 24,
  localparam int STAGE_W   = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pktValid,
  input  logic [ID_W-1:0]    pktFlow,
  output logic               pktStall,
  input  logic               recValid,
  input  logic [ID_W-1:0]    recFlow,
  input  logic [STAGE_W-1:0] recStage,
  input  logic [CNT_W-1:0]   recCount,
  output logic               recStall,
  output logic               fwdValid,
  output logic [ID_W-1:0]    fwdFlow,
  output logic               reqValid,
  output logic [ID_W-1:0]    reqFlow,
  output logic [STAGE_W-1:0] reqStage,
  output logic [CNT_W-1:0]   reqMin,
  input  logic               dumpStart,
  output logic               dumpBusy,
  output logic               dumpValid,
  output logic [STAGE_W-1:0] dumpStage,
  output logic [IDX_W-1:0]   dumpIndex,
  output logic               dumpUsed,
  output logic [ID_W-1:0]    dumpFlow,
  output logic [CNT_W-1:0]   dumpCount
);
  hhStrobes_t         strb;
  logic [STAGE_W-1:0] curStage;
  logic [IDX_W-1:0]   curIndex;
  logic [CNT_W-1:0]   minCount;
  logic               heads;

  hhCtrl #(.STAGES(STAGES), .IDX_W(IDX_W), .STAGE_W(STAGE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .recValid(recValid),
    .dumpStart(dumpStart), .strb(strb), .pktStall(pktStall), .recStall(recStall),
    .dumpBusy(dumpBusy), .curStage(curStage), .curIndex(curIndex)
  );

  hhCoin #(.CNT_W(CNT_W), .RND_W(RND_W)) i_coin (
    .clk(clk), .rstN(rstN), .cmin(minCount), .heads(heads)
  );

  hhDatapath #(
    .STAGES(STAGES), .IDX_W(IDX_W), .ID_W(ID_W), .CNT_W(CNT_W),
    .INIT_COUNT(INIT_COUNT), .STAGE_W(STAGE_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pktFlow(pktFlow), .recFlow(recFlow),
    .recStage(recStage), .recCount(recCount), .curStage(curStage), .curIndex(curIndex),
    .heads(heads), .minCount(minCount), .fwdValid(fwdValid), .fwdFlow(fwdFlow),
    .reqValid(reqValid), .reqFlow(reqFlow), .reqStage(reqStage), .reqMin(reqMin),
    .dumpValid(dumpValid), .dumpStage(dumpStage), .dumpIndex(dumpIndex),
    .dumpUsed(dumpUsed), .dumpFlow(dumpFlow), .dumpCount(dumpCount)
  );

  // R4: an accepted packet is forwarded unchanged on the next cycle
  p_fwd_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktStall) |=> (fwdValid && (fwdFlow == $past(pktFlow))));
  // R8: a recirculation taken alongside a packet leaves no forward behind
  p_rec_priority_r8: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !recStall && pktValid) |=> !fwdValid);
  // R9: a stalled packet during readout produces no forward
  p_dump_blocks_pkt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dumpBusy && !recValid) |=> !fwdValid);
endmodule

// File: tb/test_hh_table_top.sv
module test_hh_table_top;
  localparam int CLK_PERIOD = 10;
  localparam int NST = 3;
  localparam int NIX = 8;
  localparam logic [15:0] SAT = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktValid = 1'b0;
  logic [15:0] pktFlow = '0;
  logic        pktStall;
  logic        recValid = 1'b0;
  logic [15:0] recFlow = '0;
  logic [1:0]  recStage = '0;
  logic [15:0] recCount = '0;
  logic        recStall;
  logic        fwdValid;
  logic [15:0] fwdFlow;
  logic        reqValid;
  logic [15:0] reqFlow;
  logic [1:0]  reqStage;
  logic [15:0] reqMin;
  logic        dumpStart = 1'b0;
  logic        dumpBusy;
  logic        dumpValid;
  logic [1:0]  dumpStage;
  logic [2:0]  dumpIndex;
  logic        dumpUsed;
  logic [15:0] dumpFlow;
  logic [15:0] dumpCount;

  int tests = 0;
  int fails = 0;
  int headsSeen = 0;

  logic        mUsed [NST][NIX];
  logic [15:0] mId   [NST][NIX];
  logic [15:0] mCnt  [NST][NIX];

  always #(CLK_PERIOD/2) clk = ~clk;

  hh_table_top i_hh_table_top (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktFlow(pktFlow), .pktStall(pktStall),
    .recValid(recValid), .recFlow(recFlow), .recStage(recStage), .recCount(recCount),
    .recStall(recStall), .fwdValid(fwdValid), .fwdFlow(fwdFlow), .reqValid(reqValid),
    .reqFlow(reqFlow), .reqStage(reqStage), .reqMin(reqMin), .dumpStart(dumpStart),
    .dumpBusy(dumpBusy), .dumpValid(dumpValid), .dumpStage(dumpStage),
    .dumpIndex(dumpIndex), .dumpUsed(dumpUsed), .dumpFlow(dumpFlow), .dumpCount(dumpCount)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] hashOf(input int s, input logic [15:0] f);
    return f[2:0] ^ f[3*(s+1) +: 3];
  endfunction

  task automatic modelReset();
    for (int s = 0; s < NST; s++)
      for (int i = 0; i < NIX; i++) begin
        mUsed[s][i] = 1'b0; mId[s][i] = '0; mCnt[s][i] = 16'd100;
      end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic recWrite(input logic [15:0] f, input int s, input logic [15:0] c);
    logic [2:0] ix;
    @(negedge clk);
    recValid = 1'b1; recFlow = f; recStage = 2'(s); recCount = c;
    @(negedge clk);
    recValid = 1'b0;
    ix = hashOf(s, f);
    mUsed[s][ix] = 1'b1; mId[s][ix] = f; mCnt[s][ix] = (c == SAT) ? SAT : c + 16'd1;
  endtask

  task automatic sendPkt(input logic [15:0] f);
    int hs; int ms; logic [15:0] mc; logic [2:0] ix;
    @(negedge clk);
    pktValid = 1'b1; pktFlow = f;
    @(negedge clk);
    pktValid = 1'b0;
    check(fwdValid && fwdFlow == f, "R4 forward", {15'd0, fwdValid, fwdFlow}, {16'd1, f});
    hs = -1;
    for (int s = NST-1; s >= 0; s--) begin
      ix = hashOf(s, f);
      if (mUsed[s][ix] && mId[s][ix] == f) hs = s;
    end
    if (hs >= 0) begin
      ix = hashOf(hs, f);
      if (mCnt[hs][ix] != SAT) mCnt[hs][ix] = mCnt[hs][ix] + 16'd1;
      check(!reqValid, "R3 no request on match", 32'(reqValid), 32'd0);
    end else begin
      ms = 0; mc = mCnt[0][hashOf(0, f)];
      for (int s = 1; s < NST; s++)
        if (mCnt[s][hashOf(s, f)] < mc) begin mc = mCnt[s][hashOf(s, f)]; ms = s; end
      if (reqValid) begin
        headsSeen++;
        check(reqFlow == f && int'(reqStage) == ms && reqMin == mc, "R5 request fields",
              {reqFlow, 6'd0, reqStage, reqMin[7:0]}, {f, 6'd0, 2'(ms), mc[7:0]});
      end
    end
  endtask

  task automatic dumpCompare(input bit hold, input string tag);
    logic [15:0] holdFlow;
    @(negedge clk);
    dumpStart = 1'b1;
    @(negedge clk);
    dumpStart = 1'b0;
    if (hold) begin
      holdFlow = mId[0][hashOf(0, mId[0][0])];
      pktValid = 1'b1; pktFlow = mId[0][0];
      recValid = 1'b1; recFlow = 16'h7777; recStage = 2'd0; recCount = 16'd3;
      #1;
      check(pktStall && recStall && dumpBusy, "R9 stall during readout",
            {29'd0, pktStall, recStall, dumpBusy}, 32'd7);
      if (holdFlow == 16'h0) holdFlow = 16'h1;
    end
    for (int k = 0; k < NST*NIX; k++) begin
      int s; int i;
      @(negedge clk);
      s = k / NIX; i = k % NIX;
      if (hold && k == NST*NIX-1) begin pktValid = 1'b0; recValid = 1'b0; end
      check(dumpValid && int'(dumpStage) == s && int'(dumpIndex) == i &&
            dumpUsed == mUsed[s][i] && dumpCount == mCnt[s][i] &&
            (!mUsed[s][i] || dumpFlow == mId[s][i]),
            tag, {dumpValid, 3'd0, 2'(dumpStage), 3'(dumpIndex), dumpUsed, dumpCount, dumpFlow[5:0]},
            {1'b1, 3'd0, 2'(s), 3'(i), mUsed[s][i], mCnt[s][i], mId[s][i][5:0]});
    end
    @(negedge clk);
    check(!dumpValid && !dumpBusy, "R9 readout ends", {30'd0, dumpValid, dumpBusy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    int lo;
    doReset();
    @(negedge clk);
    check(!fwdValid && !reqValid && !dumpValid && !dumpBusy && !pktStall, "R1 idle outputs",
          {27'd0, fwdValid, reqValid, dumpValid, dumpBusy, pktStall}, 32'd0);
    dumpCompare(1'b0, "R1 R9 empty table readout");

    // R6: empty table, every packet unmatched with minimum 100 at stage 0, rate 1/64
    headsSeen = 0;
    for (int k = 0; k < 1024; k++) sendPkt(16'(k*37 + 5));
    check(headsSeen >= 2 && headsSeen <= 60, "R6 rate at count 100", 32'(headsSeen), 32'd16);

    // R2 R7: sweep of recirculated writes across all stages
    for (int k = 0; k < 24; k++)
      recWrite(16'(k*16'h0911 + 3), k % NST, (k == 23) ? SAT : 16'(k*5));
    dumpCompare(1'b0, "R2 R7 write placement");

    // R3: repeated hits, including the saturated entry
    for (int s = 0; s < NST; s++)
      for (int i = 0; i < NIX; i++)
        if (mUsed[s][i]) begin
          logic [15:0] f;
          f = mId[s][i];
          for (int r = 0; r < 3; r++) sendPkt(f);
        end
    dumpCompare(1'b0, "R3 counts after hits");

    // R9: held inputs during readout leave the tables unchanged
    dumpCompare(1'b1, "R9 readout with held inputs");
    dumpCompare(1'b0, "R9 tables unchanged after stall");

    // R5 R6: minimum at a non-lowest stage, count 1 so rate 1/2
    doReset();
    recWrite(16'h0123, 2, 16'd0);
    recWrite(16'h0123 ^ 16'h4000, 1, 16'd5);
    headsSeen = 0;
    for (int k = 0; k < 64; k++) sendPkt(16'h0123 ^ 16'h8000);
    check(headsSeen >= 12 && headsSeen <= 52, "R6 rate at count 1", 32'(headsSeen), 32'd32);

    // R5: tie at count 1 between stage 0 and stage 2 goes to stage 0
    recWrite(16'h0123 ^ 16'h2000, 0, 16'd0);
    headsSeen = 0;
    for (int k = 0; k < 64; k++) sendPkt(16'h0123 ^ 16'h8000);
    check(headsSeen >= 12 && headsSeen <= 52, "R5 tie run produced requests", 32'(headsSeen), 32'd32);

    // R8: recirculation wins over a packet in the same cycle
    @(negedge clk);
    pktValid = 1'b1; pktFlow = 16'h0123;
    recValid = 1'b1; recFlow = 16'h0555; recStage = 2'd1; recCount = 16'd9;
    #1;
    check(pktStall && !recStall, "R8 packet stalled", {30'd0, pktStall, recStall}, 32'd2);
    @(negedge clk);
    pktValid = 1'b0; recValid = 1'b0;
    check(!fwdValid, "R8 no forward", 32'(fwdValid), 32'd0);
    lo = hashOf(1, 16'h0555);
    mUsed[1][lo] = 1'b1; mId[1][lo] = 16'h0555; mCnt[1][lo] = 16'd10;
    dumpCompare(1'b0, "R8 recirculation applied, packet not counted");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule